// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Six sources feed it with pending flags: two external lines, three timers and a serial port. The third timer presents two flags, overflow and external event, which share one request. The block holds a source-enable register with a global gate and a priority register. Each source is placed at one of two levels, low or high.

The core supplies a sample strobe once per machine cycle at a late phase of the cycle. At that strobe the block copies the flags into a sampled set. During the following machine cycle it polls that set and shows the winning request with its vector address. A request is granted only at a strobe where the core marks the current cycle as the last cycle of an instruction. On the grant, the block pulses a one-hot acknowledge for the winning source, which a peripheral can use to clear an edge-latched flag. It also sets the in-service bit of the granted level.

A return pulse from the core clears the highest in-service level. A low-level routine can be interrupted only by a high-level request. A high-level routine cannot be interrupted at all.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `insvc`, `take_ack` and `irq_pend` are zero, and both configuration readbacks read 0x00.
- R2: The enable register has these bit positions: external 0 in bit 0, timer 0 in bit 1, external 1 in bit 2, timer 1 in bit 3, serial in bit 4, timer 2 in bit 5, and the global gate in bit 7. Bit 6 always reads 0, so writing 0xFF reads back 0xBF. The priority register uses the same bit for each source, with 1 meaning high level. Its bits 6 and 7 read 0, so writing 0xFF reads back 0x3F.
- R3: A source takes no part in arbitration while its own enable bit is 0 or while the global gate (enable bit 7) is 0. In either case `irq_pend` stays 0.
- R4: Flags are captured only on the clock edge where `smp_stb` is 1. `irq_pend` and `irq_vec` reflect that capture from the following clock onward. A flag pulse that rises and falls between strobes is never seen.
- R5: The vector is 0x0003 + 8 × index, with index 0 to 5 in the bit order of R2. This gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B. `irq_vec` is 0 while `irq_pend` is 0.
- R6: Either `t2_ovf` or `t2_ext` raises the single timer-2 request (index 5, vector 0x002B, acknowledge bit 5).
- R7: Among pending requests at the same level, the lowest index wins.
- R8: A pending high-level request wins over any pending low-level request.
- R9: A grant occurs at a clock edge only if `smp_stb` = 1, `instr_last` = 1, `ret_pulse` = 0 and `irq_pend` = 1. On the next clock, `take_ack` is a one-clock one-hot pulse for the winner. In the same clock, the in-service bit of the granted level is set: `insvc[0]` for low, `insvc[1]` for high.
- R10: While `insvc[0]` = 1, low-level requests are held off. While `insvc[1]` = 1, all requests are held off. Held-off requests keep `irq_pend` at 0.
- R11: On a clock edge with `ret_pulse` = 1, `insvc[1]` is cleared if it is set. Otherwise `insvc[0]` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_we | input | 1 | Write strobe for the enable register |
| cfg_pri_we | input | 1 | Write strobe for the priority register |
| cfg_wdata | input | 8 | Configuration write data |
| en_rd | output | 8 | Enable register readback |
| pri_rd | output | 8 | Priority register readback |
| src_flag | input | 5 | Pending flags of sources 0 to 4 |
| t2_ovf | input | 1 | Timer-2 overflow flag |
| t2_ext | input | 1 | Timer-2 external-event flag |
| smp_stb | input | 1 | Once-per-machine-cycle sample strobe |
| instr_last | input | 1 | Current machine cycle is the last cycle of an instruction |
| ret_pulse | input | 1 | Return-from-interrupt handshake |
| irq_pend | output | 1 | A grantable request is pending |
| irq_vec | output | 16 | Vector address of the pending request |
| take_ack | output | 6 | One-hot acknowledge pulse of the granted source |
| insvc | output | 2 | In-service bits (bit 0 low level, bit 1 high level) |

## Verification
Every stimulus is applied with the strobe and then given a full machine cycle of four clocks before anything is sampled.

The results fall due at these points:
- `irq_pend` and `irq_vec` are due one clock after the strobe that captured the flags.
- `take_ack` and the changed `insvc` are due one clock after the granting strobe.
- An `insvc` change caused by a return is due one clock after the returning edge.

The driver pushes each expected acknowledge index into a queue before the granting strobe. A monitor samples `take_ack` on every falling edge, pops the queue whenever the acknowledge is nonzero and compares the two. An acknowledge that arrives with an empty queue is a failure, and so is an expected item still queued at the end.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  localparam int unsigned NUM_LVL = 2;

  function automatic logic [31:0] vec_addr(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned idx);
    return 32'(base + step * idx);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned NSRC   = 6,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned EA_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             pri_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_rd,
  output logic [REG_W-1:0] pri_rd,
  output logic [NSRC-1:0]  en_src,
  output logic [NSRC-1:0]  pri_src,
  output logic             ea
);

  localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << NSRC) - 1);
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | REG_W'(1 << EA_BIT);

  logic [REG_W-1:0] en_q, en_d;
  logic [REG_W-1:0] pri_q, pri_d;

  always_comb begin
    en_d  = en_q;
    pri_d = pri_q;
    if (en_we)  en_d  = wdata & EN_MASK;
    if (pri_we) pri_d = wdata & SRC_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (pri_we) pri_q <= pri_d;
    end
  end

  assign en_rd   = en_q;
  assign pri_rd  = pri_q;
  assign en_src  = en_q[NSRC-1:0];
  assign pri_src = pri_q[NSRC-1:0];
  assign ea      = en_q[EA_BIT];

endmodule

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] smp_q
);

  logic [NSRC-1:0] smp_d;

  always_comb begin
    smp_d = smp_q;
    if (stb) smp_d = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else if (stb) smp_q <= smp_d;
  end

  // R4
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(smp_q));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N    = 6,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  output logic            hit,
  output logic [IDXW-1:0] idx
);

  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end

endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       grant_hi,
  input  logic       ret,
  output logic [1:0] insvc_q
);

  import irq_pkg::*;

  logic [1:0] insvc_d;

  always_comb begin
    insvc_d = insvc_q;
    if (ret) begin
      if (insvc_q[LVL_HI]) insvc_d[LVL_HI] = 1'b0;
      else                 insvc_d[LVL_LO] = 1'b0;
    end else if (grant) begin
      if (grant_hi) insvc_d[LVL_HI] = 1'b1;
      else          insvc_d[LVL_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= '0;
    else if (ret || grant) insvc_q <= insvc_d;
  end

  // R10
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !insvc_q[1]);

  // R10
  lo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !grant_hi) |-> (insvc_q == 2'b00));

  // R11
  ret_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && insvc_q[1]) |=> (insvc_q == {1'b0, $past(insvc_q[0])}));

  // R11
  ret_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && insvc_q == 2'b01) |=> (insvc_q == 2'b00));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned NSRC     = 6,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned EA_BIT   = 7,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en_we,
  input  logic             cfg_pri_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] en_rd,
  output logic [REG_W-1:0] pri_rd,
  input  logic [NSRC-2:0]  src_flag,
  input  logic             t2_ovf,
  input  logic             t2_ext,
  input  logic             smp_stb,
  input  logic             instr_last,
  input  logic             ret_pulse,
  output logic             irq_pend,
  output logic [VEC_W-1:0] irq_vec,
  output logic [NSRC-1:0]  take_ack,
  output logic [1:0]       insvc
);

  import irq_pkg::*;

  localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] en_src, pri_src, raw, smp;
  logic            ea;
  logic [NUM_LVL-1:0] lvl_hit;
  logic [IDXW-1:0]    lvl_idx [NUM_LVL];
  logic            use_hi, use_lo, grant;
  logic [IDXW-1:0] win_idx;
  logic [NSRC-1:0] ack_d, ack_q;
  logic [1:0]      insvc_q;

  irq_cfg_regs #(.NSRC(NSRC), .REG_W(REG_W), .EA_BIT(EA_BIT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (cfg_en_we),
    .pri_we  (cfg_pri_we),
    .wdata   (cfg_wdata),
    .en_rd   (en_rd),
    .pri_rd  (pri_rd),
    .en_src  (en_src),
    .pri_src (pri_src),
    .ea      (ea)
  );

  // the last source merges the two timer-2 flags
  assign raw = {t2_ovf | t2_ext, src_flag};

  irq_sampler #(.NSRC(NSRC)) u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (smp_stb),
    .raw   (raw),
    .smp_q (smp)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NSRC-1:0] lreq;
    assign lreq = smp & en_src & {NSRC{ea}} & ((l == int'(LVL_HI)) ? pri_src : ~pri_src);
    irq_pick #(.N(NSRC), .IDXW(IDXW)) u_pick (
      .req (lreq),
      .hit (lvl_hit[l]),
      .idx (lvl_idx[l])
    );
  end

  always_comb begin
    use_hi  = lvl_hit[LVL_HI] & ~insvc_q[LVL_HI];
    use_lo  = ~lvl_hit[LVL_HI] & lvl_hit[LVL_LO] & ~insvc_q[LVL_HI] & ~insvc_q[LVL_LO];
    win_idx = use_hi ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
  end

  assign irq_pend = use_hi | use_lo;
  assign irq_vec  = irq_pend ? VEC_W'(vec_addr(VEC_BASE, VEC_STEP, 32'(win_idx))) : '0;
  assign grant    = smp_stb & instr_last & ~ret_pulse & irq_pend;

  always_comb begin
    ack_d = '0;
    if (grant) ack_d = NSRC'(1) << win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;
  end

  irq_nest u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .grant_hi (use_hi),
    .ret      (ret_pulse),
    .insvc_q  (insvc_q)
  );

  assign take_ack = ack_q;
  assign insvc    = insvc_q;

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));

  // R9
  ack_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_q) |-> $past(smp_stb && instr_last && !ret_pulse));

  // R3
  ea_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq_pend);

endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en_we, cfg_pri_we;
  logic [7:0]  cfg_wdata, en_rd, pri_rd;
  logic [4:0]  fl;
  logic        t2_ovf, t2_ext, smp_stb, instr_last, ret_pulse;
  logic        irq_pend;
  logic [15:0] irq_vec;
  logic [5:0]  take_ack;
  logic [1:0]  insvc;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_en_we(cfg_en_we), .cfg_pri_we(cfg_pri_we),
    .cfg_wdata(cfg_wdata), .en_rd(en_rd), .pri_rd(pri_rd), .src_flag(fl),
    .t2_ovf(t2_ovf), .t2_ext(t2_ext), .smp_stb(smp_stb), .instr_last(instr_last),
    .ret_pulse(ret_pulse), .irq_pend(irq_pend), .irq_vec(irq_vec),
    .take_ack(take_ack), .insvc(insvc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each acknowledge against the scoreboard
  always @(negedge clk) begin
    if (rst_n && take_ack != 6'd0) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 unexpected ack actual=%0h expected=none", take_ack);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R9 ack source", 32'(take_ack), 32'(6'd1 << e));
      end
    end
  end

  task automatic expect_take(input int src);
    exp_q.push_back(src);
  endtask

  task automatic wr_cfg(input logic en, input logic [7:0] d);
    @(negedge clk);
    cfg_en_we = en; cfg_pri_we = ~en; cfg_wdata = d;
    @(negedge clk);
    cfg_en_we = 1'b0; cfg_pri_we = 1'b0;
  endtask

  // one machine cycle: strobe in the first clock, then three quiet clocks
  task automatic mc(input logic last, input logic ret);
    @(negedge clk);
    smp_stb = 1'b1; instr_last = last; ret_pulse = ret;
    @(negedge clk);
    smp_stb = 1'b0; instr_last = 1'b0; ret_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en_we = 0; cfg_pri_we = 0; cfg_wdata = 0;
    fl = 0; t2_ovf = 0; t2_ext = 0; smp_stb = 0; instr_last = 0; ret_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 insvc", 32'(insvc), 0);
    chk("R1 ack", 32'(take_ack), 0);
    chk("R1 pend", 32'(irq_pend), 0);
    chk("R1 en_rd", 32'(en_rd), 0);
    chk("R1 pri_rd", 32'(pri_rd), 0);

    // R2 readback masks
    wr_cfg(1'b1, 8'hFF); chk("R2 en bit6 zero", 32'(en_rd), 32'hBF);
    wr_cfg(1'b0, 8'hFF); chk("R2 pri top zero", 32'(pri_rd), 32'h3F);
    wr_cfg(1'b0, 8'h00);

    // R3 global gate off
    wr_cfg(1'b1, 8'h01); fl = 5'b00001; mc(0, 0);
    chk("R3 gate off", 32'(irq_pend), 0);
    // R3 individual enable off
    wr_cfg(1'b1, 8'h80); mc(0, 0);
    chk("R3 enable off", 32'(irq_pend), 0);

    // R5/R9 external 0, not last cycle then last cycle
    wr_cfg(1'b1, 8'h81); mc(0, 0);
    chk("R5 pend ext0", 32'(irq_pend), 1);
    chk("R5 vec ext0", 32'(irq_vec), 32'h0003);
    mc(0, 0);
    chk("R9 no grant mid-instr", 32'(insvc), 0);
    expect_take(0); mc(1, 0);
    chk("R9 low insvc", 32'(insvc), 2'b01);
    chk("R10 low blocks low", 32'(irq_pend), 0);
    fl = 0; mc(0, 1);
    chk("R11 ret low", 32'(insvc), 0);

    // R7 polling order: timer 0 before external 1
    wr_cfg(1'b1, 8'h8F); fl = 5'b00110; mc(0, 0);
    chk("R7 tmr0 first", 32'(irq_vec), 32'h000B);
    expect_take(1); mc(1, 0);
    fl = 5'b00100; mc(0, 1);
    chk("R7 ext1 next", 32'(irq_vec), 32'h0013);
    expect_take(2); mc(1, 0);
    fl = 0; mc(0, 1);

    // R8 high level beats low; serial high
    wr_cfg(1'b1, 8'h93); wr_cfg(1'b0, 8'h10);
    fl = 5'b10010; mc(0, 0);
    chk("R8 ser high wins", 32'(irq_vec), 32'h0023);
    expect_take(4); mc(1, 0);
    chk("R9 high insvc", 32'(insvc), 2'b10);
    fl = 5'b10011; mc(0, 0);
    chk("R10 high blocks all", 32'(irq_pend), 0);
    fl = 5'b00011; mc(0, 1);
    chk("R11 ret high", 32'(insvc), 0);
    chk("R7 ext0 over tmr0", 32'(irq_vec), 32'h0003);
    expect_take(0); mc(1, 0);
    // nesting: high preempts low
    fl = 5'b10011; mc(0, 0);
    chk("R10 high over low insvc", 32'(irq_vec), 32'h0023);
    expect_take(4); mc(1, 0);
    chk("R9 nested insvc", 32'(insvc), 2'b11);
    fl = 5'b00011; mc(0, 1);
    chk("R11 high cleared first", 32'(insvc), 2'b01);
    fl = 0; mc(0, 1);
    chk("R11 then low", 32'(insvc), 0);

    // R9 no grant on the return strobe
    wr_cfg(1'b1, 8'h91);
    fl = 5'b10000; mc(0, 0);
    expect_take(4); mc(1, 0);
    fl = 5'b00001; mc(0, 0);
    chk("R10 pend while high", 32'(irq_pend), 0);
    mc(1, 1);
    chk("R9 ret strobe no grant", 32'(insvc), 0);
    chk("R9 pend after ret", 32'(irq_vec), 32'h0003);
    expect_take(0); mc(1, 0);
    fl = 0; mc(0, 1);

    // R6 timer 2, each flag
    wr_cfg(1'b0, 8'h00); wr_cfg(1'b1, 8'hA0);
    t2_ext = 1; mc(0, 0);
    chk("R6 t2 ext vec", 32'(irq_vec), 32'h002B);
    expect_take(5); mc(1, 0);
    t2_ext = 0; mc(0, 1);
    t2_ovf = 1; mc(0, 0);
    chk("R6 t2 ovf vec", 32'(irq_vec), 32'h002B);
    expect_take(5); mc(1, 0);
    t2_ovf = 0; mc(0, 1);
    chk("R6 idle after", 32'(irq_pend), 0);

    // R4 a pulse between strobes is not seen
    wr_cfg(1'b1, 8'h81);
    @(negedge clk); fl = 5'b00001; @(negedge clk); fl = 0;
    mc(0, 0);
    chk("R4 short pulse missed", 32'(irq_pend), 0);
    // R4 a flag raised without a strobe is not visible
    fl = 5'b00001; repeat (3) @(negedge clk);
    chk("R4 no strobe", 32'(irq_pend), 0);
    fl = 0;

    repeat (2) @(negedge clk);
    chk("R9 all acks seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule